// File: doc/BRIEF.md
# Time-Shared Stereo Serial Audio Port

This block links a sample-processing core to a two-wire serial audio stream. A word clock (`lrck`) divides every frame into two channel halves and a bit clock (`bck`) times the individual bits. Both clocks are brought into the system clock domain and their edges are detected there. One input pin is deserialised into a shift register. A separate output pin is fed from a second shift register. Words move between these shift registers and a single mono input holding register and a single mono output holding register at every `lrck` transition. The core visits each holding register once per half, so the one register pair carries both channels in turn.

Each direction is offset from the serial stream by one half frame. The word the core reads in a half is the word received during the half before it. The word the core writes in a half is transmitted during the half after it. For two system clocks after each `lrck` transition the port is busy and closed to the core. Writes offered in that window are dropped. The core reads through a valid/ready pair (`di_valid`/`di_ready`) and writes through a valid/ready pair (`do_valid`/`do_ready`). Neither side can stall the stream. If the core does not read in time, the input word is replaced at the next transition. The output word that goes out is the last write accepted in the preceding half. If no write was accepted, the word is sent again.

Top module: `spp_port`

## Requirements
- R1: With `serial_sel_n` high the port is idle: `sdata_out`, `busy`, `di_valid` and `do_ready` stay 0 whatever the serial clocks do.
- R2: `fmt_code` is sampled at each `lrck` transition and sets the word length for that half: 0 gives 16 bits, 1 gives 18, 2 gives 20, 3 gives 24, and 4 to 7 give 16.
- R3: Input is MSB first and left-justified. The first N `bck` rising edges after an `lrck` transition carry the word. It is presented on `di_data` right-aligned in bits N-1..0, with upper bits 0. Bits beyond N are ignored.
- R4: Output is MSB first. The word's top bit (bit N-1 of the written value) is on `sdata_out` before the first `bck` rising edge of the half, and it advances on each `bck` falling edge. After N bits the line is 0.
- R5: The word read from `di_data` in a half is the one received during the previous half.
- R6: A word accepted on the write interface in a half is transmitted in the next half.
- R7: `busy` is high for exactly 2 system clocks, starting in the cycle in which the `lrck` transition is detected. `di_valid` and `do_ready` are 0 while it is high.
- R8: A write offered while `do_ready` is 0 has no effect on the transmitted data.
- R9: If several writes are accepted in one half, the last one is transmitted. If none is accepted, the previously held word is transmitted again.
- R10: `phase` equals the `lrck` level of the current half (0 = low half, 1 = high half), and it is updated at the transition.
- R11: `di_valid` rises after each transition once busy ends, and it falls after a read handshake until the next transition.
- R12: After reset both holding registers are 0, `phase` is 0 and `sdata_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the `bck` rate |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_sel_n | input | 1 | Strap: low enables the serial port |
| fmt_code | input | 3 | Word-length code |
| lrck | input | 1 | Word clock, one level per channel half |
| bck | input | 1 | Bit clock |
| sdata_in | input | 1 | Serial input data |
| sdata_out | output | 1 | Serial output data |
| busy | output | 1 | Core access closed around an `lrck` transition |
| phase | output | 1 | Current channel half |
| di_valid | output | 1 | Input word available for reading |
| di_ready | input | 1 | Core takes the input word |
| di_data | output | 24 | Input holding register |
| do_valid | input | 1 | Core offers an output word |
| do_ready | output | 1 | Output register accepts a write |
| do_data | input | 24 | Output word from the core |

## Verification
An output holding register that is loaded at the wrong moment, or a write that slips through during the busy window, shows up one half frame later as wrong bits on `sdata_out`. The bench catches it there by comparing each half's whole captured serial pattern. A deserialiser count that runs past the word length shows up as set upper bits in the next half's `di_data`. A misdecoded format code shifts the whole transmitted pattern left or right. A busy window of the wrong length is seen within three system clocks of the transition, through `busy`, `do_ready` and `di_valid`.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned LEN_W  = $clog2(DATA_W + 1);

  function automatic logic [LEN_W-1:0] fmt_len(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd1:    n = LEN_W'(18);
      3'd2:    n = LEN_W'(20);
      3'd3:    n = LEN_W'(24);
      default: n = LEN_W'(16);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/spp_edge_sync.sv
module spp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck_raw,
  input  logic bck_raw,
  input  logic sdi_raw,
  output logic lrck_lvl,
  output logic lrck_chg,
  output logic bck_rise,
  output logic bck_fall,
  output logic sdi_sync
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] stg [STAGES];
  logic [NSIG-1:0] last;
  logic            lrck_d, bck_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= {sdi_raw, bck_raw, lrck_raw};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign last = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrck_d <= 1'b0;
      bck_d  <= 1'b0;
    end else begin
      lrck_d <= last[0];
      bck_d  <= last[1];
    end
  end

  assign lrck_lvl = last[0];
  assign lrck_chg = last[0] ^ lrck_d;
  assign bck_rise = last[1] & ~bck_d;
  assign bck_fall = ~last[1] & bck_d;
  assign sdi_sync = last[2];

  a_r4_one_bck_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bck_rise |=> !bck_rise);
endmodule

// File: rtl/spp_gate.sv
module spp_gate #(
  parameter int unsigned BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lrck_lvl,
  input  logic lrck_chg,
  output logic busy,
  output logic phase
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (lrck_chg) begin
      cnt   <= CW'(BUSY_CYC - 1);
      phase <= lrck_lvl;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign busy = en & (lrck_chg | (cnt != '0));

  // R7: the window opens on a detected transition and does not stretch.
  a_r7_busy_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lrck_chg) |-> busy);
  a_r7_busy_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> (!busy || lrck_chg));
  // R10: the phase follows the half just entered.
  a_r10_phase_track: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lrck_chg) |=> (phase == $past(lrck_lvl)));
endmodule

// File: rtl/spp_deser.sv
module spp_deser #(
  parameter int unsigned W     = 24,
  parameter int unsigned LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             latch,
  input  logic [LEN_W-1:0] len_new,
  input  logic             bit_rise,
  input  logic             sdi,
  output logic [W-1:0]     word
);
  logic [W-1:0]     sr;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_r;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sr    <= '0;
      cnt   <= '0;
      len_r <= LEN_W'(16);
    end else if (latch) begin
      sr    <= '0;
      cnt   <= '0;
      len_r <= len_new;
    end else if (bit_rise && (cnt < len_r)) begin
      sr    <= {sr[W-2:0], sdi};
      cnt   <= cnt + 1'b1;
    end
  end

  assign word = sr;

  // R3: the captured count never exceeds the selected word length.
  a_r3_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len_r);
endmodule

// File: rtl/spp_ser.sv
module spp_ser #(
  parameter int unsigned W     = 24,
  parameter int unsigned LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             latch,
  input  logic [LEN_W-1:0] len_new,
  input  logic [W-1:0]     word,
  input  logic             bit_fall,
  output logic             sout
);
  localparam logic [LEN_W-1:0] W_L = LEN_W'(W);

  logic [W-1:0]     sr;
  logic [LEN_W-1:0] sent;
  logic [LEN_W-1:0] len_r;
  logic [W-1:0]     mask;
  logic [W-1:0]     aligned;

  assign mask    = (W'(1) << len_new) - W'(1);
  assign aligned = (word & mask) << (W_L - len_new);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sr    <= '0;
      sent  <= '0;
      len_r <= LEN_W'(16);
    end else if (latch) begin
      sr    <= aligned;
      sent  <= '0;
      len_r <= len_new;
    end else if (bit_fall) begin
      sr    <= {sr[W-2:0], 1'b0};
      if (sent < W_L) sent <= sent + 1'b1;
    end
  end

  assign sout = sr[W-1];

  // R4: once the word length is used up the line carries zeros.
  a_r4_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !latch && sent >= len_r) |-> !sout);
endmodule

// File: rtl/spp_port.sv
module spp_port #(
  parameter int unsigned DATA_W      = spp_pkg::DATA_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BUSY_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_sel_n,
  input  logic [2:0]        fmt_code,
  input  logic              lrck,
  input  logic              bck,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              busy,
  output logic              phase,
  output logic              di_valid,
  input  logic              di_ready,
  output logic [DATA_W-1:0] di_data,
  input  logic              do_valid,
  output logic              do_ready,
  input  logic [DATA_W-1:0] do_data
);
  localparam int unsigned LEN_W = $clog2(DATA_W + 1);

  logic              en_q;
  logic              lrck_lvl, lrck_chg, bck_rise, bck_fall, sdi_s;
  logic              latch;
  logic [LEN_W-1:0]  len_new;
  logic [DATA_W-1:0] shift_word;
  logic [DATA_W-1:0] di_q, do_q;
  logic              di_full;
  logic              ser_bit;
  logic              rd_fire, wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ~serial_sel_n;
  end

  spp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrck_raw (lrck),
    .bck_raw  (bck),
    .sdi_raw  (sdata_in),
    .lrck_lvl (lrck_lvl),
    .lrck_chg (lrck_chg),
    .bck_rise (bck_rise),
    .bck_fall (bck_fall),
    .sdi_sync (sdi_s)
  );

  spp_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .lrck_lvl (lrck_lvl),
    .lrck_chg (lrck_chg),
    .busy     (busy),
    .phase    (phase)
  );

  assign latch   = en_q & lrck_chg;
  assign len_new = LEN_W'(spp_pkg::fmt_len(fmt_code));

  spp_deser #(.W(DATA_W), .LEN_W(LEN_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .latch    (latch),
    .len_new  (len_new),
    .bit_rise (bck_rise),
    .sdi      (sdi_s),
    .word     (shift_word)
  );

  spp_ser #(.W(DATA_W), .LEN_W(LEN_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .latch    (latch),
    .len_new  (len_new),
    .word     (do_q),
    .bit_fall (bck_fall),
    .sout     (ser_bit)
  );

  assign di_valid = en_q & di_full & ~busy;
  assign do_ready = en_q & ~busy;
  assign rd_fire  = di_valid & di_ready;
  assign wr_fire  = do_valid & do_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      di_q    <= '0;
      di_full <= 1'b0;
    end else if (latch) begin
      di_q    <= shift_word;
      di_full <= 1'b1;
    end else if (rd_fire) begin
      di_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) do_q <= '0;
    else if (wr_fire)    do_q <= do_data;
  end

  assign di_data   = di_q;
  assign sdata_out = en_q & ser_bit;

  // R1: a held-high strap keeps the pins quiet.
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_sel_n && $past(serial_sel_n)) |-> (!sdata_out && !do_ready && !di_valid));
  // R8: refused writes leave the output register untouched.
  a_r8_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && do_valid && !do_ready) |=> $stable(do_q));
  // R11: a completed read withdraws the word until the next transition.
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (di_valid && di_ready && !lrck_chg) |=> !di_valid);
  // R7: no access is offered in the cycle a transition is seen.
  a_r7_closed_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_chg |-> (!do_ready && !di_valid));
endmodule

// File: tb/test_spp_port.sv
module test_spp_port;
  localparam int W    = 24;
  localparam int PH   = 6;
  localparam int BITS = 32;
  localparam int NH   = 14;

  logic         clk = 1'b0;
  logic         rst_n, serial_sel_n, lrck, bck, sdata_in;
  logic [2:0]   fmt_code;
  logic         sdata_out, busy, phase, di_valid, di_ready, do_valid, do_ready;
  logic [W-1:0] di_data, do_data;

  always #2.5 clk = ~clk;

  spp_port i_spp_port (
    .clk(clk), .rst_n(rst_n), .serial_sel_n(serial_sel_n), .fmt_code(fmt_code),
    .lrck(lrck), .bck(bck), .sdata_in(sdata_in), .sdata_out(sdata_out),
    .busy(busy), .phase(phase), .di_valid(di_valid), .di_ready(di_ready),
    .di_data(di_data), .do_valid(do_valid), .do_ready(do_ready), .do_data(do_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] di_exp_q[$];
  logic [W-1:0] do_exp_q[$];
  logic [W-1:0] last_do = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 18;
      3'd2: return 20;
      3'd3: return 24;
      default: return 16;
    endcase
  endfunction

  // Driver for the serial side plus monitor for sdata_out.
  task automatic serial_half(input logic [W-1:0] w, input int n, input bit idle);
    logic [BITS-1:0] cap  = '0;
    logic [BITS-1:0] expv = '0;
    logic [W-1:0]    e;
    lrck = ~lrck;
    for (int i = 0; i < BITS; i++) begin
      bck      = 1'b0;
      sdata_in = (i < n) ? w[n-1-i] : 1'b1;
      repeat (PH) @(negedge clk);
      cap[BITS-1-i] = sdata_out;
      bck = 1'b1;
      repeat (PH) @(negedge clk);
    end
    if (idle) begin
      chk(cap == '0, "R1 idle serial out", cap, 32'd0);
    end else begin
      e = do_exp_q.pop_front();
      for (int i = 0; i < n; i++) expv[BITS-1-i] = e[n-1-i];
      chk(cap == expv, "R2 R4 R6 R9 serial word", cap, expv);
    end
  endtask

  // Core side: mode 0 plain write, 1 write only during busy (R8),
  // 2 two writes (R9 last wins), 3 no write (R9 repeat).
  task automatic core_half(input int mode, input logic [W-1:0] wv, input logic exp_ph);
    logic [W-1:0] e;
    @(posedge busy);
    @(negedge clk);
    chk(busy && !di_valid && !do_ready, "R7 closed at window start",
        {29'd0, busy, di_valid, do_ready}, 32'h4);
    if (mode == 1) begin do_valid = 1'b1; do_data = ~wv; end
    @(negedge clk);
    chk(busy == 1'b1, "R7 second busy cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    do_valid = 1'b0;
    chk(!busy && do_ready, "R7 window ends after two clocks",
        {30'd0, busy, do_ready}, 32'h1);
    chk(phase == exp_ph, "R10 phase", {31'd0, phase}, {31'd0, exp_ph});
    chk(di_valid, "R11 word offered after window", {31'd0, di_valid}, 32'd1);
    e = di_exp_q.pop_front();
    chk(di_data == e, "R3 R5 input word", {8'd0, di_data}, {8'd0, e});
    di_ready = 1'b1;
    if (mode == 0) begin do_valid = 1'b1; do_data = wv; last_do = wv; end
    if (mode == 2) begin do_valid = 1'b1; do_data = ~wv; end
    @(negedge clk);
    di_ready = 1'b0;
    chk(!di_valid, "R11 cleared by read", {31'd0, di_valid}, 32'd0);
    if (mode == 2) begin do_data = wv; last_do = wv; end
    else do_valid = 1'b0;
    @(negedge clk);
    do_valid = 1'b0;
    do_exp_q.push_back(last_do);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; serial_sel_n = 1'b0; lrck = 1'b0; bck = 1'b0; sdata_in = 1'b0;
    fmt_code = 3'd0; di_ready = 1'b0; do_valid = 1'b0; do_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sdata_out && !busy && !di_valid && !phase, "R12 reset state",
        {28'd0, sdata_out, busy, di_valid, phase}, 32'd0);
    chk(do_ready, "R12 write open after reset", {31'd0, do_ready}, 32'd1);
    di_exp_q.push_back('0);
    do_exp_q.push_back('0);

    for (int h = 0; h < NH; h++) begin
      logic [W-1:0] win, wout;
      logic         nl;
      int           n, md;
      fmt_code = 3'(h % 6);
      n    = len_of(fmt_code);
      win  = 24'hA5C3F1 ^ (24'(h) * 24'h13579B);
      wout = 24'h3C96E1 + (24'(h) * 24'h0F0F11);
      md   = (h < 2) ? 0 : (h % 4);
      nl   = ~lrck;
      di_exp_q.push_back(win & ((24'd1 << n) - 24'd1));
      fork
        serial_half(win, n, 1'b0);
        core_half(md, wout, nl);
      join
    end

    serial_sel_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !di_valid && !do_ready, "R1 idle handshake",
        {29'd0, busy, di_valid, do_ready}, 32'd0);
    serial_half(24'hFFFFFF, 24, 1'b1);
    serial_half(24'h123456, 24, 1'b1);
    chk(!busy && !di_valid, "R1 idle after clocks", {30'd0, busy, di_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule